// File: doc/BRIEF.md
# Host-to-Microcontroller Byte Mailbox

This block lets a 16-bit host processor swap single bytes with a slow microcontroller that owns only a handful of GPIO pins. On the host side, two odd offsets inside a 256-byte I/O window are decoded. The offset a byte is written to marks it as a command or as data. The host then polls a busy bit until the microcontroller has taken the byte. The host never stalls on the serial side: it writes, polls, and reads the reply byte.

On the microcontroller side there are three strobes (load, shift, acknowledge) and four level pins (busy status, command/data, serial bit in, serial bit out). The microcontroller waits for status, pulses load, and clocks eight shift pulses. Each shift pulse moves one bit in each direction at the same time. It then pulses acknowledge. That single acknowledge frees the mailbox and places the byte it shifted in where the host can read it. The strobes come from an unrelated time base, so they are synchronized and acted on at their rising edges. A host write that lands on a still-busy mailbox replaces the byte and raises a sticky overrun bit.

Top module: `hmb_mailbox`

## Requirements
- R1: After reset, status, overrun, command/data and the reply byte are all 0, and `mcu_dout` is 0.
- R2: A selected low-lane write (`host_wr_lo`) to offset 0xF1 or 0xF3 stores `host_wdata` and sets status to 1. Status is visible on `mcu_status` after the clock edge that samples the write.
- R3: Such a write also records its offset. `mcu_is_data` is 0 after a write to 0xF1 (command) and 1 after a write to 0xF3 (data).
- R4: A write to any other offset, or a write without `host_sel`, changes neither the stored byte nor any flag.
- R5: While `host_sel` and `host_rd` are high, `host_rdata` reflects the addressed offset in the same cycle. At 0xF1 it gives status on bit 0, overrun on bit 1 and zeros above. At 0xF3 it gives the reply byte on bits 7:0 and zeros above. Any other offset, or no read, gives 0.
- R6: Each microcontroller strobe acts exactly once per rising level. The action lands on the second clock edge after the edge that first samples the strobe high, and holding the strobe high does nothing further.
- R7: A load strobe copies the stored host byte into the outgoing shift register. `mcu_dout` always shows that register's bit 7.
- R8: A shift strobe moves the outgoing register one place toward bit 7, so bits leave most significant first. In the same action it appends the synchronized `mcu_din` at bit 0 of the incoming register, so after eight shifts the first bit taken in sits at bit 7.
- R9: An acknowledge strobe clears status and copies the incoming shift register into the reply byte.
- R10: A host write while status is 1 overwrites the stored byte and sets overrun. Overrun stays set until a host read of 0xF1, which returns it and then clears it on that read's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host I/O window select |
| host_addr | input | 8 | Byte offset inside the window |
| host_wdata | input | 8 | Host low data lane for writes |
| host_wr_lo | input | 1 | Host low-lane write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data |
| mcu_load | input | 1 | Microcontroller load strobe (asynchronous) |
| mcu_shift | input | 1 | Microcontroller shift strobe (asynchronous) |
| mcu_ack | input | 1 | Microcontroller acknowledge strobe (asynchronous) |
| mcu_din | input | 1 | Serial bit from the microcontroller |
| mcu_dout | output | 1 | Serial bit toward the microcontroller |
| mcu_status | output | 1 | Busy flag: a host byte is waiting |
| mcu_is_data | output | 1 | 0 = command byte, 1 = data byte |

## Verification
Host writes take effect on `mcu_status`, `mcu_is_data` and the overrun bit one clock edge after they are sampled. Host reads are combinational within the strobe cycle, and the overrun clear appears after that read's edge. A strobe or serial-input change becomes effective on the third rising edge, counting the edge that first samples it. The bench keeps a behavioural model that delays the pin samples by that count. The model updates on rising edges, while every output is compared on the falling edge. Directed checks count those edges explicitly for the strobe latency and for the read-clear of overrun.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int BYTE_W = 8;
  localparam int WIN_AW = 8;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WIN_AW-1:0] off_t;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_CTRL  = 2'd1,
    RSEL_REPLY = 2'd2
  } rsel_e;

  // Incoming register: new bit enters at bit 0
  function automatic byte_t f_take_bit(byte_t r, logic b);
    return {r[BYTE_W-2:0], b};
  endfunction

  // Outgoing register: bit 7 leaves, zero fills from below
  function automatic byte_t f_give_bit(byte_t r);
    return {r[BYTE_W-2:0], 1'b0};
  endfunction

  function automatic logic f_mail_hit(off_t a, off_t cmd_off, off_t dat_off);
    return (a == cmd_off) || (a == dat_off);
  endfunction
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
  parameter int N_SIG  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] d_async,
  output logic [N_SIG-1:0] d_sync
);
  for (genvar g = 0; g < N_SIG; g++) begin : g_chain
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[g]};
    end
    assign d_sync[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/hmb_rise.sv
module hmb_rise #(
  parameter int N_SIG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] lvl,
  output logic [N_SIG-1:0] rise
);
  logic [N_SIG-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
endmodule

// File: rtl/hmb_host_side.sv
module hmb_host_side
  import hmb_pkg::*;
#(
  parameter int   BUS_W   = 16,
  parameter off_t CMD_OFF = 8'hF1,
  parameter off_t DAT_OFF = 8'hF3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  off_t             addr,
  input  byte_t            wdata,
  input  logic             wr_lo,
  input  logic             rd,
  input  logic             ack_ev,
  input  byte_t            shin,
  output byte_t            host_byte,
  output logic             status,
  output logic             is_data,
  output logic             overrun,
  output byte_t            reply,
  output logic [BUS_W-1:0] rdata,
  output logic             wr_ev,
  output logic             ovr_clr_ev
);
  localparam int PAD_W = BUS_W - BYTE_W;

  rsel_e rsel;

  assign wr_ev = sel && wr_lo && f_mail_hit(addr, CMD_OFF, DAT_OFF);

  always_comb begin
    rsel = RSEL_NONE;
    if (sel && rd) begin
      if (addr == CMD_OFF)      rsel = RSEL_CTRL;
      else if (addr == DAT_OFF) rsel = RSEL_REPLY;
    end
  end

  assign ovr_clr_ev = (rsel == RSEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= 1'b0;
      overrun   <= 1'b0;
      is_data   <= 1'b0;
      host_byte <= '0;
      reply     <= '0;
    end else begin
      // a fresh write wins over a same-cycle acknowledge
      if (wr_ev)       status <= 1'b1;
      else if (ack_ev) status <= 1'b0;

      if (wr_ev && status) overrun <= 1'b1;
      else if (ovr_clr_ev) overrun <= 1'b0;

      if (wr_ev) begin
        host_byte <= wdata;
        is_data   <= (addr == DAT_OFF);
      end

      if (ack_ev) reply <= shin;
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_CTRL:  rdata = {{(BUS_W-2){1'b0}}, overrun, status};
      RSEL_REPLY: rdata = {{PAD_W{1'b0}}, reply};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/hmb_serial_side.sv
module hmb_serial_side
  import hmb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_ev,
  input  logic  shift_ev,
  input  logic  din,
  input  byte_t host_byte,
  output byte_t shin,
  output logic  dout
);
  byte_t shout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shout <= '0;
      shin  <= '0;
    end else begin
      if (load_ev)       shout <= host_byte;
      else if (shift_ev) shout <= f_give_bit(shout);
      if (shift_ev && !load_ev) shin <= f_take_bit(shin, din);
    end
  end

  assign dout = shout[BYTE_W-1];
endmodule

// File: rtl/hmb_mailbox.sv
module hmb_mailbox
  import hmb_pkg::*;
#(
  parameter int   BUS_W       = 16,
  parameter int   SYNC_STAGES = 2,
  parameter off_t CMD_OFF     = 8'hF1,
  parameter off_t DAT_OFF     = 8'hF3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic [7:0]       host_addr,
  input  logic [7:0]       host_wdata,
  input  logic             host_wr_lo,
  input  logic             host_rd,
  output logic [BUS_W-1:0] host_rdata,
  input  logic             mcu_load,
  input  logic             mcu_shift,
  input  logic             mcu_ack,
  input  logic             mcu_din,
  output logic             mcu_dout,
  output logic             mcu_status,
  output logic             mcu_is_data
);
  localparam int N_STB = 3;
  localparam int N_PIN = N_STB + 1;

  logic [N_PIN-1:0] pin_sync;
  logic [N_STB-1:0] stb_rise;
  logic  load_ev, shift_ev, ack_ev, din_s;
  logic  wr_ev, ovr_clr_ev, status, overrun, is_data;
  byte_t host_byte, shin, reply;

  hmb_sync #(.N_SIG(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({mcu_din, mcu_ack, mcu_shift, mcu_load}),
    .d_sync (pin_sync)
  );

  hmb_rise #(.N_SIG(N_STB)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (pin_sync[N_STB-1:0]),
    .rise (stb_rise)
  );

  assign load_ev  = stb_rise[0];
  assign shift_ev = stb_rise[1];
  assign ack_ev   = stb_rise[2];
  assign din_s    = pin_sync[N_STB];

  hmb_host_side #(.BUS_W(BUS_W), .CMD_OFF(CMD_OFF), .DAT_OFF(DAT_OFF)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (host_sel),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .wr_lo     (host_wr_lo),
    .rd        (host_rd),
    .ack_ev    (ack_ev),
    .shin      (shin),
    .host_byte (host_byte),
    .status    (status),
    .is_data   (is_data),
    .overrun   (overrun),
    .reply     (reply),
    .rdata     (host_rdata),
    .wr_ev     (wr_ev),
    .ovr_clr_ev(ovr_clr_ev)
  );

  hmb_serial_side u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ev  (load_ev),
    .shift_ev (shift_ev),
    .din      (din_s),
    .host_byte(host_byte),
    .shin     (shin),
    .dout     (mcu_dout)
  );

  assign mcu_status  = status;
  assign mcu_is_data = is_data;
endmodule

// File: rtl/hmb_mailbox_chk.sv
module hmb_mailbox_chk #(
  parameter int         BUS_W   = 16,
  parameter logic [7:0] DAT_OFF = 8'hF3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ev,
  input logic             ack_ev,
  input logic             load_ev,
  input logic             shift_ev,
  input logic             ovr_clr_ev,
  input logic             status,
  input logic             overrun,
  input logic             is_data,
  input logic [7:0]       host_addr,
  input logic [7:0]       reply,
  input logic             host_sel,
  input logic             host_rd,
  input logic [BUS_W-1:0] host_rdata
);
  p_set_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> status);

  p_kind_follows_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (is_data == ($past(host_addr) == DAT_OFF)));

  p_quiet_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ev && !ack_ev) |=> $stable(status));

  p_quiet_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(is_data));

  p_idle_bus_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_sel && host_rd) |-> (host_rdata == '0));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev || load_ev || shift_ev) |=> !($past(ack_ev) && ack_ev)
                                        && !($past(load_ev) && load_ev)
                                        && !($past(shift_ev) && shift_ev));

  p_ack_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !wr_ev) |=> !status);

  p_reply_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_ev |=> $stable(reply));

  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && status) |=> overrun);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr_ev) |=> overrun);
endmodule

bind hmb_mailbox hmb_mailbox_chk #(.BUS_W(BUS_W), .DAT_OFF(DAT_OFF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_ev     (wr_ev),
  .ack_ev    (ack_ev),
  .load_ev   (load_ev),
  .shift_ev  (shift_ev),
  .ovr_clr_ev(ovr_clr_ev),
  .status    (status),
  .overrun   (overrun),
  .is_data   (is_data),
  .host_addr (host_addr),
  .reply     (reply),
  .host_sel  (host_sel),
  .host_rd   (host_rd),
  .host_rdata(host_rdata)
);

// File: tb/hmb_mailbox_bench.sv
`timescale 1ns/1ps
module hmb_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 0, host_wr_lo = 0, host_rd = 0;
  logic [7:0] host_addr = 0, host_wdata = 0;
  logic [15:0] host_rdata;
  logic mcu_load = 0, mcu_shift = 0, mcu_ack = 0, mcu_din = 0;
  logic mcu_dout, mcu_status, mcu_is_data;

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  hmb_mailbox u_hmb_mailbox (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr_lo(host_wr_lo), .host_rd(host_rd), .host_rdata(host_rdata),
    .mcu_load(mcu_load), .mcu_shift(mcu_shift), .mcu_ack(mcu_ack),
    .mcu_din(mcu_din), .mcu_dout(mcu_dout), .mcu_status(mcu_status),
    .mcu_is_data(mcu_is_data)
  );

  task automatic check(input string tag, input int got, input int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit ld_q[$], sh_q[$], ak_q[$], di_q[$];
  int m_host, m_status, m_kind, m_ovr, m_out, m_in, m_reply;

  task automatic model_clear();
    ld_q.delete(); sh_q.delete(); ak_q.delete(); di_q.delete();
    repeat (4) begin
      ld_q.push_back(0); sh_q.push_back(0); ak_q.push_back(0); di_q.push_back(0);
    end
    m_host = 0; m_status = 0; m_kind = 0; m_ovr = 0; m_out = 0; m_in = 0; m_reply = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) model_clear();
    else begin
      int last;
      bit ld, sh, ak, dv, wr, rc;
      ld_q.push_back(mcu_load); sh_q.push_back(mcu_shift);
      ak_q.push_back(mcu_ack);  di_q.push_back(mcu_din);
      last = ld_q.size() - 1;
      // a pin level sampled two edges ago, after a low one edge before that
      ld = ld_q[last-2] && !ld_q[last-3];
      sh = sh_q[last-2] && !sh_q[last-3];
      ak = ak_q[last-2] && !ak_q[last-3];
      dv = di_q[last-2];
      wr = host_sel && host_wr_lo && (host_addr == 8'hF1 || host_addr == 8'hF3);
      rc = host_sel && host_rd && host_addr == 8'hF1;
      if (ak) m_reply = m_in;
      if (ld) m_out = m_host;
      else if (sh) m_out = (m_out * 2) % 256;
      if (sh && !ld) m_in = (m_in * 2 + dv) % 256;
      if (wr && m_status == 1) m_ovr = 1;
      else if (rc) m_ovr = 0;
      if (wr) begin
        m_status = 1;
        m_host = host_wdata;
        m_kind = (host_addr == 8'hF3);
      end else if (ak) m_status = 0;
      if (ld_q.size() > 6) begin
        void'(ld_q.pop_front()); void'(sh_q.pop_front());
        void'(ak_q.pop_front()); void'(di_q.pop_front());
      end
    end
  end

  function automatic int model_rdata();
    if (!(host_sel && host_rd)) return 0;
    if (host_addr == 8'hF1) return m_ovr * 2 + m_status;
    if (host_addr == 8'hF3) return m_reply;
    return 0;
  endfunction

  always @(negedge clk) begin
    check("R9 status pin", mcu_status, m_status);
    check("R3 kind pin", mcu_is_data, m_kind);
    check("R8 serial out", mcu_dout, m_out / 128);
    check("R5 read data", host_rdata, model_rdata());
  end

  // ---------------- stimulus tasks ----------------
  task automatic host_write(input logic [7:0] off, input logic [7:0] d, input logic s = 1);
    @(posedge clk); #1;
    host_sel = s; host_wr_lo = 1; host_addr = off; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 0; host_wr_lo = 0;
  endtask

  task automatic host_read(input logic [7:0] off, output int v);
    @(posedge clk); #1;
    host_sel = 1; host_rd = 1; host_addr = off;
    #1 v = host_rdata;
    @(posedge clk); #1;
    host_sel = 0; host_rd = 0;
  endtask

  task automatic pulse(input int which, input int hold);
    @(posedge clk); #1;
    case (which) 0: mcu_load = 1; 1: mcu_shift = 1; default: mcu_ack = 1; endcase
    repeat (hold) @(posedge clk);
    #1;
    case (which) 0: mcu_load = 0; 1: mcu_shift = 0; default: mcu_ack = 0; endcase
    repeat (4) @(posedge clk);
  endtask

  task automatic mcu_exchange(input logic [7:0] give, output logic [7:0] got);
    pulse(0, 4);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      mcu_din = give[7-i];
      repeat (4) @(posedge clk);
      #1 got[7-i] = mcu_dout;
      pulse(1, 4);
    end
    pulse(2, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int v;
    logic [7:0] got;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // R1 reset state
    host_read(8'hF1, v); check("R1 ctrl after reset", v, 0);
    host_read(8'hF3, v); check("R1 reply after reset", v, 0);
    check("R1 kind pin", mcu_is_data, 0);
    check("R1 serial out", mcu_dout, 0);

    // R2/R3 command byte, R7/R8/R9 exchange
    host_write(8'hF1, 8'hA5);
    #1 check("R2 status set", mcu_status, 1);
    check("R3 command kind", mcu_is_data, 0);
    mcu_exchange(8'h5C, got);
    check("R7 byte seen by mcu", got, 8'hA5);
    check("R9 status cleared", mcu_status, 0);
    host_read(8'hF3, v); check("R9 reply", v, 8'h5C);
    check("R8 msb-first reply", v, 8'h5C);

    // R3 data byte
    host_write(8'hF3, 8'h3C);
    #1 check("R3 data kind", mcu_is_data, 1);
    mcu_exchange(8'hC3, got);
    check("R8 data byte", got, 8'h3C);
    host_read(8'hF3, v); check("R9 second reply", v, 8'hC3);

    // R4 ignored writes
    host_write(8'hF2, 8'hFF);
    host_write(8'hF1, 8'hEE, 1'b0);
    host_read(8'hF1, v); check("R4 no status from stray writes", v, 0);
    check("R4 kind kept", mcu_is_data, 1);
    host_write(8'hF3, 8'h11);
    host_write(8'h01, 8'hFF);
    host_read(8'hF1, v); check("R4 no overrun from stray write", v, 1);
    mcu_exchange(8'h00, got);
    check("R4 byte kept", got, 8'h11);

    // R5 other offset and even neighbour read as zero
    host_read(8'hF0, v); check("R5 other offset", v, 0);
    host_read(8'hF2, v); check("R5 even neighbour", v, 0);

    // R10 overrun
    host_write(8'hF1, 8'h22);
    host_write(8'hF1, 8'h99);
    host_read(8'hF1, v); check("R10 overrun flagged", v, 3);
    host_read(8'hF1, v); check("R10 overrun cleared by read", v, 1);
    mcu_exchange(8'h81, got);
    check("R10 newest byte wins", got, 8'h99);

    // R6 strobe latency: acts on the second edge after first sample
    host_write(8'hF3, 8'h44);
    @(posedge clk); #1 mcu_ack = 1;
    @(posedge clk);
    @(posedge clk); #1 check("R6 not yet acted", mcu_status, 1);
    @(posedge clk); #1 check("R6 acted on time", mcu_status, 0);
    repeat (6) @(posedge clk);
    #1 mcu_ack = 0;
    repeat (4) @(posedge clk);

    // R6 a long-held shift acts once
    host_write(8'hF1, 8'hA0);
    pulse(0, 4);
    #1 check("R7 msb after load", mcu_dout, 1);
    pulse(1, 12);
    #1 check("R6 single shift", mcu_dout, 0);
    pulse(1, 3);
    #1 check("R8 next bit", mcu_dout, 1);
    pulse(2, 4);
    check("R9 freed", mcu_status, 0);

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule